// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an external SDRAM from power-up to normal operation without any help from software. After reset it drives the SDRAM command pins directly. It holds NOP for the power-up wait and then closes every bank with a precharge-all. Next comes a fast-refresh phase, in which a short refresh interval packs at least eight auto-refresh commands into a fixed window. It then writes the mode register with a burst length that follows the external data-bus width. At the end it switches the refresh timer to the caller's normal interval and raises `ready`.

In normal operation the sequencer keeps issuing auto-refresh at the normal interval. Each auto-refresh is followed by a recovery gap of NOPs. The user read/write paths and the address mapping for user accesses live in other blocks. All timing gaps are parameters in clock cycles. The only exception is the power-up wait, which is derived from the clock frequency in MHz and the wait in microseconds.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `ready` is 0 and the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111).
- R2: After reset is released, exactly CLK_MHZ*PWRUP_US consecutive NOP cycles are issued before any other command.
- R3: The first command after the power-up wait is precharge-all (4'b0010) with address bit AP_BIT (default 10) high. It is followed by exactly T_RP NOP cycles.
- R4: During the fast-refresh phase, successive auto-refresh commands (4'b0001) are spaced exactly INIT_REF_CNT (default 11) cycles apart.
- R5: The fast-refresh phase starts in the cycle after the T_RP gap. It lasts at least INIT_WINDOW (default 80) cycles and contains at least INIT_REFS (default 8) auto-refresh commands before the mode-register set.
- R6: Every auto-refresh command is followed by exactly T_RFC NOP cycles.
- R7: The mode-register set (4'b0000) drives bank 0. The address is 0x3 (burst length 8) when `bus16_i` is 1 (16-bit bus) and 0x2 (burst length 4) when `bus16_i` is 0 (32-bit bus).
- R8: The mode-register set is followed by exactly T_MRD NOP cycles. `ready` first reads 1 in the cycle after that gap and stays 1 until reset.
- R9: Once `ready` is high, no precharge-all or mode-register set is issued. Successive auto-refresh commands are spaced exactly `norm_ref_cnt_i` cycles apart.
- R10: A reset asserted part-way through the sequence clears `ready` and restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus16_i | input | 1 | 1 = 16-bit data bus, 0 = 32-bit data bus |
| norm_ref_cnt_i | input | REF_W | Refresh interval in cycles for normal operation |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/mode address |
| ready | output | 1 | Initialization complete |

## Verification
A corrupted state or wait counter shows at the pins within one command slot. A command appears a cycle early or late, or the wrong code appears after a gap. Comparing the recorded command stream against fixed indices counted from reset release exposes this at once. A stuck refresh timer or pending flag shows up within one refresh interval as a wrong spacing between auto-refreshes. A wrong choice of phase shows up as a wrong refresh count before the mode-register set, or as a mode value that does not match the bus width.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // Command code is {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_PALL,
    ST_TRP,
    ST_FAST,
    ST_AREF,
    ST_TRFC,
    ST_MRS,
    ST_TMRD,
    ST_RUN
  } seq_st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  output logic         req_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign req_o  = en_i && !load_i && (cnt_q <= W'(1));
  assign cnt_en = load_i | en_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = period_i;
    else if (req_o) cnt_d = period_i;
    else            cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int AP_BIT  = 10,
  parameter int MODE_B4 = 2,
  parameter int MODE_B8 = 3
) (
  input  sd_cmd_e           cmd_i,
  input  logic              bus16_i,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr
);
  assign {cs_n, ras_n, cas_n, we_n} = cmd_i;
  assign ba = '0;

  always_comb begin
    addr = '0;
    case (cmd_i)
      CMD_PALL: addr[AP_BIT] = 1'b1;
      CMD_MRS:  addr = bus16_i ? ROW_W'(MODE_B8) : ROW_W'(MODE_B4);
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC   = 20000,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2,
  parameter int INIT_WINDOW = 80,
  parameter int INIT_REFS   = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ref_req_i,
  output sd_cmd_e cmd_o,
  output logic    tmr_load_o,
  output logic    tmr_en_o,
  output logic    sel_norm_o,
  output logic    ready_o
);
  localparam int M1   = (PWRUP_CYC > T_RP) ? PWRUP_CYC : T_RP;
  localparam int M2   = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int WMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(WMAX + 1);
  localparam int WW   = $clog2(INIT_WINDOW + 1);
  localparam int NW   = $clog2(INIT_REFS + 1);

  seq_st_e       state_q, state_d;
  logic [CW-1:0] wait_q, wait_d;
  logic [WW-1:0] win_q;
  logic [NW-1:0] nref_q;
  logic          pend_q, pend_d;
  logic          ready_q;
  logic          wait_zero, win_done, refs_done, in_fast, win_en, nref_en, ready_set;

  assign wait_zero = (wait_q == '0);
  assign win_done  = (win_q == WW'(INIT_WINDOW));
  assign refs_done = (nref_q == NW'(INIT_REFS));
  assign in_fast   = !ready_q && (state_q inside {ST_FAST, ST_AREF, ST_TRFC});
  assign win_en    = in_fast && !win_done;
  assign nref_en   = !ready_q && (state_q == ST_AREF) && !refs_done;
  assign ready_set = (state_q == ST_TMRD) && wait_zero;

  always_comb begin
    state_d    = state_q;
    wait_d     = wait_q;
    tmr_load_o = 1'b0;
    case (state_q)
      ST_PWRUP: if (wait_zero) state_d = ST_PALL;
                else wait_d = wait_q - CW'(1);
      ST_PALL: begin
        state_d = ST_TRP;
        wait_d  = CW'(T_RP - 1);
      end
      ST_TRP: if (wait_zero) begin
                state_d    = ST_FAST;
                tmr_load_o = 1'b1;
              end else wait_d = wait_q - CW'(1);
      ST_FAST: if (pend_q) state_d = ST_AREF;
               else if (win_done && refs_done && !ref_req_i) state_d = ST_MRS;
      ST_AREF: begin
        state_d = ST_TRFC;
        wait_d  = CW'(T_RFC - 1);
      end
      ST_TRFC: if (wait_zero) state_d = ready_q ? ST_RUN : ST_FAST;
               else wait_d = wait_q - CW'(1);
      ST_MRS: begin
        state_d = ST_TMRD;
        wait_d  = CW'(T_MRD - 1);
      end
      ST_TMRD: if (wait_zero) begin
                 state_d    = ST_RUN;
                 tmr_load_o = 1'b1;
               end else wait_d = wait_q - CW'(1);
      ST_RUN:  if (pend_q) state_d = ST_AREF;
      default: state_d = ST_PWRUP;
    endcase
  end

  always_comb begin
    if (tmr_load_o)              pend_d = 1'b0;
    else if (state_q == ST_AREF) pend_d = ref_req_i;
    else                         pend_d = pend_q | ref_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      wait_q  <= CW'(PWRUP_CYC - 1);
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nref_q <= '0;
    else if (nref_en) nref_q <= nref_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ready_q <= 1'b0;
    else if (ready_set) ready_q <= 1'b1;
  end

  always_comb begin
    case (state_q)
      ST_PALL: cmd_o = CMD_PALL;
      ST_AREF: cmd_o = CMD_AREF;
      ST_MRS:  cmd_o = CMD_MRS;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign tmr_en_o   = state_q inside {ST_FAST, ST_AREF, ST_TRFC, ST_RUN};
  assign sel_norm_o = ready_q | (state_q == ST_TMRD);
  assign ready_o    = ready_q;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PWRUP_US     = 200,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_REF_CNT = 11,
  parameter int INIT_WINDOW  = 80,
  parameter int INIT_REFS    = 8,
  parameter int ROW_W        = 13,
  parameter int BANK_W       = 2,
  parameter int REF_W        = 16,
  parameter int AP_BIT       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus16_i,
  input  logic [REF_W-1:0]  norm_ref_cnt_i,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              ready
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;

  sd_cmd_e          cmd;
  logic             ref_req, tmr_load, tmr_en, sel_norm;
  logic [REF_W-1:0] ref_period;

  assign ref_period = sel_norm ? norm_ref_cnt_i : REF_W'(INIT_REF_CNT);

  sdram_init_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .INIT_WINDOW(INIT_WINDOW), .INIT_REFS(INIT_REFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_req_i(ref_req), .cmd_o(cmd),
    .tmr_load_o(tmr_load), .tmr_en_o(tmr_en), .sel_norm_o(sel_norm),
    .ready_o(ready)
  );

  sdram_ref_timer #(.W(REF_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .en_i(tmr_en),
    .period_i(ref_period), .req_o(ref_req)
  );

  sdram_cmd_enc #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) u_enc (
    .cmd_i(cmd), .bus16_i(bus16_i), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus16_i,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ROW_W-1:0]  addr,
  input logic              ready
);
  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  assert_pall_ap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> addr[AP_BIT]);
  assert_pall_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |=> (pins == 4'b0111));
  assert_aref_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0001) |=> (pins == 4'b0111));
  assert_mode_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (ba == '0 && addr == (bus16_i ? ROW_W'(3) : ROW_W'(2))));
  assert_mrs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |=> (pins == 4'b0111 && !ready));
  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_run_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pins != 4'b0000 && pins != 4'b0010));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus16_i(bus16_i), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_P  = 10;
  localparam int ROW_W  = 13;
  localparam int BANK_W = 2;
  localparam int REF_W  = 16;
  localparam int PWRUP  = 20;   // CLK_MHZ=1 * PWRUP_US=20
  localparam int TRP    = 3;
  localparam int TRFC   = 7;
  localparam int TMRD   = 2;
  localparam int ICNT   = 11;
  localparam int IWIN   = 80;
  localparam int IREFS  = 8;
  localparam int LOGN   = 512;
  localparam logic [3:0] C_NOP = 4'b0111, C_PALL = 4'b0010,
                         C_AREF = 4'b0001, C_MRS = 4'b0000;

  logic clk, rst_n, bus16;
  logic [REF_W-1:0] norm_cnt;
  logic cs_n, ras_n, cas_n, we_n, ready;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  int n_chk, n_fail;
  logic logging;
  int lg_n;
  logic [3:0]        lg_cmd  [LOGN];
  logic [ROW_W-1:0]  lg_addr [LOGN];
  logic [BANK_W-1:0] lg_ba   [LOGN];
  logic              lg_rdy  [LOGN];

  sdram_init_seq #(
    .CLK_MHZ(1), .PWRUP_US(PWRUP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .INIT_REF_CNT(ICNT), .INIT_WINDOW(IWIN), .INIT_REFS(IREFS),
    .ROW_W(ROW_W), .BANK_W(BANK_W), .REF_W(REF_W), .AP_BIT(10)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus16_i(bus16), .norm_ref_cnt_i(norm_cnt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .ready(ready)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (logging && rst_n && lg_n < LOGN) begin
      lg_cmd[lg_n]  = {cs_n, ras_n, cas_n, we_n};
      lg_addr[lg_n] = addr;
      lg_ba[lg_n]   = ba;
      lg_rdy[lg_n]  = ready;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>=%0d", rq, act, lim);
    end
  endtask

  task automatic do_reset(input string rq);
    logging = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rq, {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(rq, ready, 0);
    @(posedge clk);
    #1;
    lg_n = 0;
    logging = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic analyze(input logic b16, input int ncnt);
    int p, m, f, bad, nref, last, runref;
    p = -1; m = -1;
    for (int i = 0; i < lg_n; i++)
      if (p < 0 && lg_cmd[i] != C_NOP) p = i;
    chk("R2 first non-NOP index", p, PWRUP);
    if (p < 0) return;
    chk("R3 precharge-all code", lg_cmd[p], C_PALL);
    chk("R3 AP bit", lg_addr[p][10], 1);
    bad = 0;
    for (int i = p + 1; i <= p + TRP; i++) if (lg_cmd[i] != C_NOP) bad++;
    chk("R3 tRP gap", bad, 0);
    f = p + 1 + TRP;
    for (int i = p + 1; i < lg_n; i++)
      if (m < 0 && lg_cmd[i] == C_MRS) m = i;
    chk_ge("R5 mode set found", m, 0);
    if (m < 0) return;
    chk_ge("R5 fast window cycles", m - f, IWIN);
    nref = 0; last = -1; bad = 0;
    for (int i = f; i < m; i++) if (lg_cmd[i] == C_AREF) begin
      nref++;
      if (last >= 0 && i - last != ICNT) bad++;
      last = i;
    end
    chk_ge("R5 fast refresh count", nref, IREFS);
    chk("R4 fast refresh spacing", bad, 0);
    bad = 0;
    for (int i = 0; i < lg_n - TRFC; i++) if (lg_cmd[i] == C_AREF)
      for (int k = 1; k <= TRFC; k++) if (lg_cmd[i+k] != C_NOP) bad++;
    chk("R6 tRFC gap", bad, 0);
    chk("R7 mode address", lg_addr[m], b16 ? 3 : 2);
    chk("R7 mode bank", lg_ba[m], 0);
    bad = 0;
    for (int i = m + 1; i <= m + TMRD; i++) if (lg_cmd[i] != C_NOP) bad++;
    chk("R8 tMRD gap", bad, 0);
    bad = 0;
    for (int i = 0; i < lg_n; i++)
      if (lg_rdy[i] != (i > m + TMRD)) bad++;
    chk("R8 ready timing", bad, 0);
    bad = 0; runref = 0; last = -1;
    for (int i = m + 1; i < lg_n; i++) begin
      if (lg_cmd[i] == C_PALL || lg_cmd[i] == C_MRS) bad++;
      if (lg_cmd[i] == C_AREF) begin
        if (last >= 0) begin
          runref++;
          chk("R9 normal refresh spacing", i - last, ncnt);
        end
        last = i;
      end
    end
    chk("R9 no setup commands in run", bad, 0);
    chk_ge("R9 normal refresh intervals seen", runref, 2);
  endtask

  task automatic run_seq(input logic b16, input int ncnt, input string rq);
    bus16 = b16;
    norm_cnt = REF_W'(ncnt);
    do_reset(rq);
    repeat (LOGN - 8) @(posedge clk);
    analyze(b16, ncnt);
  endtask

  task automatic test_bus32;
    run_seq(1'b0, 40, "R1 reset idle");
  endtask

  task automatic test_bus16;
    run_seq(1'b1, 25, "R1 reset idle");
  endtask

  task automatic test_midreset;
    bus16 = 1'b1;
    norm_cnt = REF_W'(30);
    do_reset("R1 reset idle");
    repeat (60) @(posedge clk);
    run_seq(1'b1, 30, "R10 reset mid-sequence");
  endtask

  task automatic test_ready_drop;
    bus16 = 1'b0;
    norm_cnt = REF_W'(40);
    do_reset("R1 reset idle");
    repeat (250) @(posedge clk);
    @(negedge clk);
    chk("R8 ready reached", ready, 1);
    run_seq(1'b0, 40, "R10 ready cleared by reset");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; lg_n = 0; logging = 1'b0;
    rst_n = 1'b0; bus16 = 1'b0; norm_cnt = '0;
    test_bus32();
    test_bus16();
    test_midreset();
    test_ready_drop();
    finish_run();
  end
endmodule